// File: doc/BRIEF.md
# Mode-Selectable Transmit Packet Formatter

This block turns host-supplied transmit data into a single serial bit stream for a modulator. The host writes bytes into a 64-entry byte queue through a write strobe. A 2-bit mode input picks the data path. In continuous mode a host-driven bit goes straight to the serial output. In buffered mode the queued bytes are shifted out raw, with no framing. In packet mode the block builds a whole frame by itself.

A packet frame has four parts, sent in this order: a run of 0xAA preamble bytes, a 32-bit sync word, the payload taken from the queue, and an optional CRC-16. The payload and the CRC can also be Manchester coded. Every output symbol advances on a single-cycle `tx_strobe` pulse from the bit-rate timer, and every byte is sent MSB first. When Manchester coding is on, each symbol is one chip, so the timer is expected to run at chip rate.

Sticky status flags report the end of a frame, a queue that ran dry in the middle of a frame, and writes lost to a full queue.

Top module: `tx_frame_formatter`

## Requirements
- R1: The `mode` input is decoded as 00 = continuous, 01 = buffered, 1x (10 or 11) = packet. A `start` pulse begins a frame only when the block is idle and `mode[1]` is 1. In the other modes `busy` stays 0.
- R2: In continuous mode, while the block is idle, `tx_out` equals `cont_bit` in the same cycle. Strobes in this mode remove nothing from the queue.
- R3: In buffered mode, each strobe moves to the next bit of the queued bytes, MSB first, with no preamble, sync or CRC. If the queue is empty at a byte boundary, that strobe drives 0 and pops nothing. Streaming resumes once the host writes more bytes.
- R4: Packet mode sends the following, in this order:
  - `pre_cnt`+1 bytes of 0xAA;
  - `sync_word`, MSB first;
  - `clamp(pay_len)` payload bytes from the queue, where 0 counts as 1 and values above 64 count as 64;
  - the CRC, when it is enabled.
  The strobe after `start` puts the first symbol on `tx_out`, and each later strobe puts the next one.
- R5: When `crc_en` is 1, two CRC bytes follow the payload, high byte first. The CRC is CRC-16 with polynomial 0x1021 and seed 0xFFFF, computed over the payload bytes only.
- R6: When `dcf_en` is 1, each payload and CRC bit is sent as two chips on two strobes: a 1 as 1 then 0, and a 0 as 0 then 1. The preamble and sync word are never coded.
- R7: The strobe after the last symbol of a frame drives `tx_out` to 0 and clears `busy`. The same strobe sets `done`, which stays 1 until the next accepted `start`.
- R8: If the queue is empty at the start of a payload byte, the frame is abandoned on that strobe: `busy` returns to 0, `tx_out` goes to 0, and `underflow` is set. `underflow` stays 1 until the next accepted `start`, and `done` stays 0.
- R9: The queue holds 64 bytes. A write while `fifo_full` is 1 is dropped and sets `overflow`, which stays 1 until reset.
- R10: While a frame is in progress, changes to `mode` and further `start` pulses have no effect on the output stream or on the queue.
- R11: After reset, `tx_out`, `busy`, `done`, `underflow`, `overflow` and `fifo_full` are 0, and `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Data path select (00 continuous, 01 buffered, 1x packet) |
| cont_bit | input | 1 | Bit passed through in continuous mode |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to write into the queue |
| start | input | 1 | Begin a packet frame |
| pre_cnt | input | 2 | Preamble byte count minus one |
| pay_len | input | 7 | Payload length in bytes (0 counts as 1, above 64 counts as 64) |
| sync_word | input | 32 | Sync pattern, sent MSB first |
| crc_en | input | 1 | Append the CRC-16 |
| dcf_en | input | 1 | Manchester code the payload and CRC |
| tx_strobe | input | 1 | Single-cycle pulse that advances the output by one symbol |
| tx_out | output | 1 | Serial output to the modulator |
| busy | output | 1 | A packet frame is in progress |
| done | output | 1 | The last frame completed (sticky) |
| underflow | output | 1 | The last frame was abandoned on an empty queue (sticky) |
| overflow | output | 1 | A write was dropped because the queue was full (sticky) |
| fifo_full | output | 1 | The queue holds 64 bytes |
| fifo_empty | output | 1 | The queue holds no bytes |

## Verification
Two conditions are the hardest to reach from the ports.

The first is a mode change in the middle of a frame. To reach it, the bench starts a packet frame and moves `mode` to buffered while `busy` is still 1. It also pulses `start` again during the frame. The full frame must still match, and the queue must then be empty and must give idle zeros.

The second is a payload underflow. To reach it, the bench writes fewer bytes than the programmed length, so the queue runs dry exactly at a payload byte boundary.

The largest frame tests the 64-byte payload cap: 64 bytes, with both the CRC and Manchester coding on. The queue limit is tested by writing a 65th byte and then draining all 64 stored bytes in buffered mode.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int          BYTE_W      = 8;
    localparam int          FIFO_DEPTH  = 64;
    localparam int          SYNC_W      = 32;
    localparam int          SYNC_BYTES  = SYNC_W / BYTE_W;
    localparam int          LEN_W       = $clog2(FIFO_DEPTH) + 1;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [7:0]  PRE_PATTERN = 8'hAA;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SYNC,
        PH_PAY,
        PH_CRC,
        PH_FIN
    } phase_t;

    typedef struct packed {
        phase_t           phase;
        logic [LEN_W-1:0] bidx;
        logic [2:0]       bitp;
        logic             chip;
    } pos_t;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                               input logic [7:0]  d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        if (l == '0)
            return LEN_W'(1);
        else if (l > LEN_W'(FIFO_DEPTH))
            return LEN_W'(FIFO_DEPTH);
        else
            return l;
    endfunction

    function automatic phase_t phase_after(input phase_t p, input logic crc_on);
        case (p)
            PH_PRE:  return PH_SYNC;
            PH_SYNC: return PH_PAY;
            PH_PAY:  return crc_on ? PH_CRC : PH_FIN;
            PH_CRC:  return PH_FIN;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         overflow
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          push;

    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign push  = wr_en && !full;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop && !empty)
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full)
                overflow <= 1'b1;
        end
    end

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);                                            // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !pop) |=> (full && overflow));            // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));                                   // R9

endmodule

// File: rtl/txf_bufser.sv
module txf_bufser
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              strobe,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic              ser_bit
);
    logic              need;
    logic [BYTE_W-1:0] sh;
    logic [2:0]        idx;

    assign fifo_pop = en && strobe && need && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            need    <= 1'b1;
            sh      <= '0;
            idx     <= 3'd7;
            ser_bit <= 1'b0;
        end else if (strobe) begin
            if (need) begin
                if (!fifo_empty) begin
                    ser_bit <= fifo_head[BYTE_W-1];
                    sh      <= fifo_head;
                    idx     <= 3'd6;
                    need    <= 1'b0;
                end else begin
                    ser_bit <= 1'b0;
                end
            end else begin
                ser_bit <= sh[idx];
                if (idx == 3'd0)
                    need <= 1'b1;
                else
                    idx <= idx - 1'b1;
            end
        end
    end

    AST_BUF_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (en && strobe && need && fifo_empty) |=> !ser_bit);         // R3

endmodule

// File: rtl/txf_framer.sv
module txf_framer
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  logic [1:0]        pre_cnt,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic              crc_en,
    input  logic              dcf_en,
    input  logic              strobe,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic              busy,
    output logic              pkt_bit,
    output logic              done,
    output logic              underflow
);
    pos_t              pos, nxt;
    logic [1:0]        pre_q;
    logic [LEN_W-1:0]  len_q;
    logic [SYNC_W-1:0] sync_q;
    logic              crc_on_q, dcf_q;
    logic [15:0]       crc_q;
    logic [BYTE_W-1:0] pay_q;

    logic              byte_start, manch, data_bit, sym;
    logic [BYTE_W-1:0] cur_byte;
    logic [LEN_W-1:0]  last_idx;
    logic [SYNC_W-1:0] sync_sh;
    logic              starve;

    assign busy = (pos.phase != PH_IDLE);

    always_comb begin
        byte_start = (pos.bitp == 3'd7) && !pos.chip;
        sync_sh    = sync_q << {pos.bidx[1:0], 3'b000};
        cur_byte   = '0;
        last_idx   = '0;
        case (pos.phase)
            PH_PRE: begin
                cur_byte = PRE_PATTERN;
                last_idx = LEN_W'(pre_q);
            end
            PH_SYNC: begin
                cur_byte = sync_sh[SYNC_W-1 -: BYTE_W];
                last_idx = LEN_W'(SYNC_BYTES - 1);
            end
            PH_PAY: begin
                cur_byte = byte_start ? fifo_head : pay_q;
                last_idx = len_q - 1'b1;
            end
            PH_CRC: begin
                cur_byte = pos.bidx[0] ? crc_q[7:0] : crc_q[15:8];
                last_idx = LEN_W'(1);
            end
            default: ;
        endcase
        manch    = dcf_q && ((pos.phase == PH_PAY) || (pos.phase == PH_CRC));
        data_bit = cur_byte[pos.bitp];
        sym      = (manch && pos.chip) ? !data_bit : data_bit;
        starve   = (pos.phase == PH_PAY) && byte_start && fifo_empty;

        nxt = pos;
        if (manch && !pos.chip) begin
            nxt.chip = 1'b1;
        end else begin
            nxt.chip = 1'b0;
            if (pos.bitp == 3'd0) begin
                nxt.bitp = 3'd7;
                if (pos.bidx == last_idx) begin
                    nxt.bidx  = '0;
                    nxt.phase = phase_after(pos.phase, crc_on_q);
                end else begin
                    nxt.bidx = pos.bidx + 1'b1;
                end
            end else begin
                nxt.bitp = pos.bitp - 1'b1;
            end
        end
    end

    assign fifo_pop = strobe && (pos.phase == PH_PAY) && byte_start && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '{phase: PH_IDLE, bidx: '0, bitp: 3'd7, chip: 1'b0};
            pre_q     <= '0;
            len_q     <= LEN_W'(1);
            sync_q    <= '0;
            crc_on_q  <= 1'b0;
            dcf_q     <= 1'b0;
            crc_q     <= CRC_SEED;
            pay_q     <= '0;
            pkt_bit   <= 1'b0;
            done      <= 1'b0;
            underflow <= 1'b0;
        end else if (!busy && start_ok) begin
            pos       <= '{phase: PH_PRE, bidx: '0, bitp: 3'd7, chip: 1'b0};
            pre_q     <= pre_cnt;
            len_q     <= clamp_len(pay_len);
            sync_q    <= sync_word;
            crc_on_q  <= crc_en;
            dcf_q     <= dcf_en;
            crc_q     <= CRC_SEED;
            pkt_bit   <= 1'b0;
            done      <= 1'b0;
            underflow <= 1'b0;
        end else if (strobe && busy) begin
            if (pos.phase == PH_FIN) begin
                pos.phase <= PH_IDLE;
                pkt_bit   <= 1'b0;
                done      <= 1'b1;
            end else if (starve) begin
                pos.phase <= PH_IDLE;
                pkt_bit   <= 1'b0;
                underflow <= 1'b1;
            end else begin
                pkt_bit <= sym;
                pos     <= nxt;
                if (fifo_pop) begin
                    pay_q <= fifo_head;
                    crc_q <= crc16_byte(crc_q, fifo_head);
                end
            end
        end
    end

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !strobe) |=> $stable(pkt_bit));                    // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                            // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && underflow));                                      // R8
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (busy && strobe && (pos.phase == PH_FIN)) |=> (!pkt_bit && !busy)); // R7

endmodule

// File: rtl/tx_frame_formatter.sv
module tx_frame_formatter
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              cont_bit,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              start,
    input  logic [1:0]        pre_cnt,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic              crc_en,
    input  logic              dcf_en,
    input  logic              tx_strobe,
    output logic              tx_out,
    output logic              busy,
    output logic              done,
    output logic              underflow,
    output logic              overflow,
    output logic              fifo_full,
    output logic              fifo_empty
);
    logic [BYTE_W-1:0] head;
    logic              pkt_pop, buf_pop, fifo_pop;
    logic              pkt_bit, buf_bit, buf_en;

    assign buf_en   = (mode == 2'b01) && !busy;
    assign fifo_pop = pkt_pop || buf_pop;

    txf_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pop      (fifo_pop),
        .head     (head),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .overflow (overflow)
    );

    txf_bufser u_buf (
        .clk        (clk),
        .rst        (rst),
        .en         (buf_en),
        .strobe     (tx_strobe),
        .fifo_empty (fifo_empty),
        .fifo_head  (head),
        .fifo_pop   (buf_pop),
        .ser_bit    (buf_bit)
    );

    txf_framer u_frm (
        .clk        (clk),
        .rst        (rst),
        .start_ok   (start && mode[1]),
        .pre_cnt    (pre_cnt),
        .pay_len    (pay_len),
        .sync_word  (sync_word),
        .crc_en     (crc_en),
        .dcf_en     (dcf_en),
        .strobe     (tx_strobe),
        .fifo_empty (fifo_empty),
        .fifo_head  (head),
        .fifo_pop   (pkt_pop),
        .busy       (busy),
        .pkt_bit    (pkt_bit),
        .done       (done),
        .underflow  (underflow)
    );

    always_comb begin
        if (busy)
            tx_out = pkt_bit;
        else if (mode == 2'b00)
            tx_out = cont_bit;
        else if (mode == 2'b01)
            tx_out = buf_bit;
        else
            tx_out = pkt_bit;
    end

    AST_CONT_NO_POP: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00) && !busy) |-> !fifo_pop);                  // R2
    AST_START_NEEDS_PKT: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !mode[1]) |=> !busy);                    // R1
    AST_ONE_POPPER: assert property (@(posedge clk) disable iff (rst)
        !(pkt_pop && buf_pop));                                     // R10

endmodule

// File: tb/sim_tx_frame_formatter.sv
module sim_tx_frame_formatter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        cont_bit = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        start = 1'b0;
    logic [1:0]  pre_cnt = '0;
    logic [6:0]  pay_len = '0;
    logic [31:0] sync_word = '0;
    logic        crc_en = 1'b0;
    logic        dcf_en = 1'b0;
    logic        tx_strobe = 1'b0;
    logic        tx_out, busy, done, underflow, overflow, fifo_full, fifo_empty;

    always #5 clk = ~clk;

    tx_frame_formatter u0 (
        .clk(clk), .rst(rst), .mode(mode), .cont_bit(cont_bit),
        .wr_en(wr_en), .wr_data(wr_data), .start(start), .pre_cnt(pre_cnt),
        .pay_len(pay_len), .sync_word(sync_word), .crc_en(crc_en),
        .dcf_en(dcf_en), .tx_strobe(tx_strobe), .tx_out(tx_out), .busy(busy),
        .done(done), .underflow(underflow), .overflow(overflow),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit expb [0:1199];
    int nexp;

    // vector fields: [1:0] pre_cnt, [8:2] length, [9] crc_en, [10] dcf_en,
    // [18:11] payload seed, [19] use mode 11 instead of 10
    localparam int NVEC = 5;
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 8'h3C, 1'b0, 1'b0, 7'd1,  2'd0},
        {1'b0, 8'h01, 1'b0, 1'b1, 7'd5,  2'd3},
        {1'b1, 8'hF0, 1'b1, 1'b1, 7'd4,  2'd1},
        {1'b0, 8'h7E, 1'b1, 1'b1, 7'd64, 2'd2},
        {1'b1, 8'h00, 1'b1, 1'b0, 7'd3,  2'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic strobe1();
        @(negedge clk) tx_strobe = 1'b1;
        @(negedge clk) tx_strobe = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [7:0] pay_byte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic add_byte(input logic [7:0] b, input bit man);
        for (int i = 7; i >= 0; i--) begin
            expb[nexp] = b[i]; nexp++;
            if (man) begin expb[nexp] = !b[i]; nexp++; end
        end
    endtask

    task automatic build(input int pre, input int len, input bit crc,
                         input bit dcf, input logic [7:0] seed,
                         input logic [31:0] sw);
        logic [15:0] c;
        logic [7:0]  b;
        nexp = 0;
        c = 16'hFFFF;
        for (int p = 0; p <= pre; p++) add_byte(8'hAA, 1'b0);
        for (int s = 3; s >= 0; s--) add_byte(sw[s*8 +: 8], 1'b0);
        for (int i = 0; i < len; i++) begin
            b = pay_byte(seed, i);
            add_byte(b, dcf);
            c = c ^ {b, 8'h00};
            for (int k = 0; k < 8; k++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        if (crc) begin
            add_byte(c[15:8], dcf);
            add_byte(c[7:0], dcf);
        end
    endtask

    task automatic compare_bits(input int n, input string req);
        int bad = 0;
        int first = -1;
        int fa = 0, fe = 0;
        for (int k = 0; k < n; k++) begin
            strobe1();
            if (tx_out !== expb[k]) begin
                if (first < 0) begin first = k; fa = int'(tx_out); fe = int'(expb[k]); end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("frame bit %0d", first), fa, fe);
    endtask

    initial begin : main
        logic [19:0] v;
        logic [31:0] sw;
        logic [7:0]  got;
        int          bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(tx_out == 1'b0 && busy == 1'b0, "R11", "tx_out/busy", {tx_out, busy}, 0);
        check(done == 0 && underflow == 0 && overflow == 0 && fifo_full == 0,
              "R11", "flags", {done, underflow, overflow, fifo_full}, 0);
        check(fifo_empty == 1'b1, "R11", "fifo_empty", fifo_empty, 1);

        // R2 continuous pass-through; R1 start ignored outside packet mode
        mode = 2'b00;
        push(8'hC3);
        cont_bit = 1'b1; #1;
        check(tx_out == 1'b1, "R2", "cont high", tx_out, 1);
        cont_bit = 1'b0; #1;
        check(tx_out == 1'b0, "R2", "cont low", tx_out, 0);
        repeat (4) strobe1();
        check(fifo_empty == 1'b0, "R2", "no pop in continuous", fifo_empty, 0);
        pulse_start();
        check(busy == 1'b0, "R1", "start in mode 00", busy, 0);
        mode = 2'b01;
        pulse_start();
        check(busy == 1'b0, "R1", "start in mode 01", busy, 0);

        // R3 buffered raw streaming, idle zero, refill
        nexp = 0;
        add_byte(8'hC3, 1'b0);
        compare_bits(8, "R3");
        strobe1();
        check(tx_out == 1'b0, "R3", "empty gives 0", tx_out, 0);
        push(8'h5A);
        push(8'h81);
        nexp = 0;
        add_byte(8'h5A, 1'b0);
        add_byte(8'h81, 1'b0);
        compare_bits(16, "R3");
        check(fifo_empty == 1'b1, "R3", "drained", fifo_empty, 1);

        // R4 R5 R6 R7 R1: table of packet frames
        for (int t = 0; t < NVEC; t++) begin
            v  = VEC[t];
            sw = 32'hB42E_7D19 ^ {4{v[18:11]}};
            mode      = v[19] ? 2'b11 : 2'b10;
            pre_cnt   = v[1:0];
            pay_len   = v[8:2];
            crc_en    = v[9];
            dcf_en    = v[10];
            sync_word = sw;
            for (int i = 0; i < int'(v[8:2]); i++) push(pay_byte(v[18:11], i));
            build(int'(v[1:0]), int'(v[8:2]), v[9], v[10], v[18:11], sw);
            pulse_start();
            check(busy == 1'b1, "R1", $sformatf("vec %0d start accepted", t), busy, 1);
            compare_bits(nexp, v[10] ? "R6" : (v[9] ? "R5" : "R4"));
            check(busy == 1'b1 && done == 1'b0, "R7", "still busy before end",
                  {busy, done}, 2);
            strobe1();
            check(busy == 1'b0 && done == 1'b1 && tx_out == 1'b0, "R7",
                  $sformatf("vec %0d end", t), {busy, done, tx_out}, 2);
        end

        // R10 mode change and extra start during a frame
        mode = 2'b10; pre_cnt = 2'd0; pay_len = 7'd2; crc_en = 1'b1; dcf_en = 1'b0;
        sync_word = 32'h1357_9BDF;
        push(pay_byte(8'h44, 0));
        push(pay_byte(8'h44, 1));
        build(0, 2, 1'b1, 1'b0, 8'h44, 32'h1357_9BDF);
        pulse_start();
        for (int k = 0; k < 10; k++) strobe1();
        mode = 2'b01;
        pulse_start();
        bad = 0;
        for (int k = 10; k < nexp; k++) begin
            strobe1();
            if (tx_out !== expb[k]) bad++;
        end
        check(bad == 0, "R10", "frame after mode change", bad, 0);
        strobe1();
        check(done == 1'b1 && busy == 1'b0, "R10", "frame completed", {done, busy}, 2);
        strobe1();
        check(tx_out == 1'b0 && fifo_empty == 1'b1, "R10", "queue untouched by buffered",
              {tx_out, fifo_empty}, 1);

        // R8 underflow
        mode = 2'b10; pre_cnt = 2'd0; pay_len = 7'd3; crc_en = 1'b0; dcf_en = 1'b0;
        sync_word = 32'hA5A5_0F0F;
        push(pay_byte(8'h10, 0));
        push(pay_byte(8'h10, 1));
        build(0, 3, 1'b0, 1'b0, 8'h10, 32'hA5A5_0F0F);
        pulse_start();
        compare_bits(56, "R8");
        check(busy == 1'b1, "R8", "busy before starve", busy, 1);
        strobe1();
        check(underflow == 1'b1 && busy == 1'b0 && done == 1'b0 && tx_out == 1'b0,
              "R8", "abandoned", {underflow, busy, done, tx_out}, 8);

        // R9 queue depth and overflow drop
        do_reset();
        mode = 2'b01;
        for (int i = 0; i < 65; i++) push(8'(i));
        check(fifo_full == 1'b1 && overflow == 1'b1, "R9", "full and overflow",
              {fifo_full, overflow}, 3);
        bad = 0;
        for (int b = 0; b < 64; b++) begin
            got = '0;
            for (int k = 0; k < 8; k++) begin
                strobe1();
                got = {got[6:0], tx_out};
            end
            if (got != 8'(b)) bad++;
        end
        check(bad == 0, "R9", "64 stored bytes in order", bad, 0);
        check(fifo_empty == 1'b1 && overflow == 1'b1, "R9", "65th dropped, sticky",
              {fifo_empty, overflow}, 3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #1500000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule